// File: doc/BRIEF.md
# NAND Completion Status Poller

This block waits for a raw NAND device to finish a program or erase that another part of the controller has already started. After a start pulse it drives one command-latch cycle that carries the status-read opcode, releases the command latch while keeping chip enable asserted, and then fetches status bytes through the controller's read-data path. It keeps polling until the ready bit comes back set or the allowed time runs out.

Polls are spaced by a fixed interval of `POLL_US` microseconds. The block derives that interval from the `CLK_HZ` parameter. Elapsed waiting time is accumulated in steps of that interval and compared against a limit given in milliseconds. The limit is sampled when the start pulse is accepted. When the poller stops, it pulses `done_o` for one cycle and presents a two-bit outcome in that same cycle: success, timeout or device failure. The timeout test is made before the fail bit is looked at.

Top module: `nand_status_poll`

## Requirements
- R1: While reset is active and after it is released with no start, `done_o`, `nand_ce_o`, `nand_cle_o`, `nand_we_o` and `rd_req_o` are all low.
- R2: An accepted start produces exactly one command cycle. In that cycle `nand_ce_o`, `nand_cle_o` and `nand_we_o` are high and `nand_cmd_o` is 8'h70. No other command strobe occurs during the operation.
- R3: In the cycle after the command cycle, `nand_ce_o` is high and both `nand_cle_o` and `nand_we_o` are low.
- R4: Each status read is requested by a one-cycle `rd_req_o` pulse, and the byte is taken in the cycle where `rd_vld_i` is high. When that byte has status bit 6 (ready) clear, the next `rd_req_o` comes exactly `POLL_US`·`CLK_HZ`/1e6 + 1 cycles after the `rd_vld_i` cycle.
- R5: If ready never sets, the block stops after exactly `tmo_ms_i`·(1000/`POLL_US`) + 1 status reads. This is the point where the accumulated wait first exceeds `tmo_ms_i`·1000 µs, so a limit of zero still gives one read.
- R6: Result code 2'b01 (timeout) is reported whenever the last byte read has bit 6 clear, whatever the value of bit 0 (fail).
- R7: Result code 2'b10 (failure) is reported when the last byte has bit 6 set and bit 0 set.
- R8: Result code 2'b00 (success) is reported when the last byte has bit 6 set and bit 0 clear. The other six status bits have no effect on the result.
- R9: `done_o` is high for exactly one cycle per operation, and `result_o` is valid in that cycle. `nand_ce_o` is low in the `done_o` cycle and stays low until the next start.
- R10: A start pulse that arrives while an operation is in progress is ignored. It causes no second command cycle, no extra `done_o` and no change to the read count.
- R11: Polling stops at the first byte with bit 6 set, so the number of reads equals that byte's position in the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a status wait (taken only when idle) |
| tmo_ms_i | input | TMO_W | Timeout limit in milliseconds, sampled at start |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 success, 01 timeout, 10 device failure; valid with `done_o` |
| nand_ce_o | output | 1 | Chip enable drive, active high |
| nand_cle_o | output | 1 | Command latch enable drive |
| nand_we_o | output | 1 | Command write strobe |
| nand_cmd_o | output | 8 | Command byte, 8'h70 during the command cycle |
| rd_req_o | output | 1 | Request one status byte from the read-data path |
| rd_vld_i | input | 1 | Status byte present on `rd_data_i` |
| rd_data_i | input | 8 | Status byte from the device |

## Verification
The bench targets the boundary of the timeout count. It uses a limit of zero, which must still allow one read, and it places the ready byte exactly on the last permitted read and one read past it. A design with an off-by-one in its elapsed comparison either reports success where it should time out or makes one read too many or too few. Non-ready bytes are sent with the fail bit set, so a design that tests fail before ready reports failure instead of timeout. Random filler bits are mixed into ready bytes, so a design that decodes the wrong bit positions reports the wrong outcome. The bench also measures the exact gap between polls. A second start is sent mid-operation, and a design that re-triggers on it shows a second command cycle.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_REL, ST_READ, ST_WAITRD, ST_WAIT, ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_TMO  = 2'b01,
    RES_FAIL = 2'b10
  } res_e;

  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam int         BIT_RDY    = 6;
  localparam int         BIT_FAIL   = 0;
endpackage

// File: rtl/nsp_interval.sv
// Counts one polling interval after each load; expire_o marks its last cycle.
module nsp_interval #(
  parameter int IVL_CYC = 2500,
  localparam int CNT_W  = (IVL_CYC > 1) ? $clog2(IVL_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = CNT_W'(IVL_CYC - 1);
      run_d  = 1'b1;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

  // R4
  single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !load_i) |=> !expire_o);
endmodule

// File: rtl/nsp_elapsed.sv
// Accumulates waited time in POLL_US steps against a millisecond limit.
module nsp_elapsed #(
  parameter int TMO_W   = 16,
  parameter int POLL_US = 10,
  localparam int ACC_W  = TMO_W + 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [TMO_W-1:0] tmo_ms_i,
  input  logic             step_i,
  output logic             over_next_o
);
  localparam logic [ACC_W:0] STEP = (ACC_W + 1)'(POLL_US);

  logic [ACC_W-1:0] elapsed_q, elapsed_d;
  logic [ACC_W-1:0] limit_q, limit_d;
  logic             acc_en;
  logic [ACC_W:0]   sum;

  assign sum         = {1'b0, elapsed_q} + STEP;
  assign over_next_o = sum > {1'b0, limit_q};

  always_comb begin
    elapsed_d = elapsed_q;
    limit_d   = limit_q;
    acc_en    = 1'b0;
    if (clr_i) begin
      elapsed_d = '0;
      limit_d   = ACC_W'(tmo_ms_i) * ACC_W'(1000);
      acc_en    = 1'b1;
    end else if (step_i) begin
      elapsed_d = sum[ACC_W-1:0];
      acc_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      limit_q   <= '0;
    end else if (acc_en) begin
      elapsed_q <= elapsed_d;
      limit_q   <= limit_d;
    end
  end

  // R5
  within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q <= limit_q);
endmodule

// File: rtl/nand_status_poll.sv
module nand_status_poll #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int POLL_US = 10,
  parameter int TMO_W   = 16,
  localparam int CYC_PER_US = CLK_HZ / 1_000_000,
  localparam int IVL_CYC    = CYC_PER_US * POLL_US
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TMO_W-1:0] tmo_ms_i,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             nand_ce_o,
  output logic             nand_cle_o,
  output logic             nand_we_o,
  output logic [7:0]       nand_cmd_o,
  output logic             rd_req_o,
  input  logic             rd_vld_i,
  input  logic [7:0]       rd_data_i
);
  import nsp_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  state_e     state_q, state_d;
  logic [1:0] res_q, res_d;
  logic       res_en;
  logic [7:0] stat_q;
  logic       stat_en;
  logic       clr, load, step, expire, over_next;

  nsp_interval #(.IVL_CYC(IVL_CYC)) i_interval (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (load),
    .expire_o (expire)
  );

  nsp_elapsed #(.TMO_W(TMO_W), .POLL_US(POLL_US)) i_elapsed (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .clr_i       (clr),
    .tmo_ms_i    (tmo_ms_i),
    .step_i      (step),
    .over_next_o (over_next)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    res_en  = 1'b0;
    clr     = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    stat_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CMD;
        clr     = 1'b1;
      end
      ST_CMD:  state_d = ST_REL;
      ST_REL:  state_d = ST_READ;
      ST_READ: state_d = ST_WAITRD;
      ST_WAITRD: if (rd_vld_i) begin
        stat_en = 1'b1;
        if (rd_data_i[BIT_RDY]) begin
          state_d = ST_DONE;
          res_en  = 1'b1;
          res_d   = rd_data_i[BIT_FAIL] ? RES_FAIL : RES_OK;
        end else begin
          state_d = ST_WAIT;
          load    = 1'b1;
        end
      end
      ST_WAIT: if (expire) begin
        if (over_next) begin
          state_d = ST_DONE;
          res_en  = 1'b1;
          res_d   = RES_TMO;
        end else begin
          state_d = ST_READ;
          step    = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    res_q <= RES_OK;
    else if (res_en) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     stat_q <= '0;
    else if (stat_en) stat_q <= rd_data_i;
  end

  assign nand_ce_o  = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign nand_cle_o = (state_q == ST_CMD);
  assign nand_we_o  = (state_q == ST_CMD);
  assign nand_cmd_o = (state_q == ST_CMD) ? CMD_STATUS : 8'h00;
  assign rd_req_o   = (state_q == ST_READ);
  assign done_o     = (state_q == ST_DONE);
  assign result_o   = res_q;

  // R2
  cle_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    nand_cle_o |-> (nand_ce_o && nand_we_o));
  // R3
  cle_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    nand_cle_o |=> (nand_ce_o && !nand_cle_o && !nand_we_o));
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_req_o |=> !rd_req_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> (!done_o && !nand_ce_o));
  // R6
  tmo_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && result_o == RES_TMO) |-> !stat_q[BIT_RDY]);
  // R8
  ok_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_o && result_o == RES_OK) |-> (stat_q[BIT_RDY] && !stat_q[BIT_FAIL]));
endmodule

// File: tb/test_nand_status_poll.sv
module test_nand_status_poll;
  localparam int CLK_HZ  = 1_000_000;
  localparam int POLL_US = 10;
  localparam int TMO_W   = 16;
  localparam int IVL     = (CLK_HZ / 1_000_000) * POLL_US;
  localparam int NEVER   = 1_000_000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [TMO_W-1:0] tmo_ms_i = '0;
  logic             done_o;
  logic [1:0]       result_o;
  logic             nand_ce_o, nand_cle_o, nand_we_o, rd_req_o;
  logic [7:0]       nand_cmd_o;
  logic             rd_vld_i = 1'b0;
  logic [7:0]       rd_data_i = '0;

  always #2 clk = ~clk;

  nand_status_poll #(.CLK_HZ(CLK_HZ), .POLL_US(POLL_US), .TMO_W(TMO_W)) i_nand_status_poll (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmo_ms_i(tmo_ms_i),
    .done_o(done_o), .result_o(result_o), .nand_ce_o(nand_ce_o),
    .nand_cle_o(nand_cle_o), .nand_we_o(nand_we_o), .nand_cmd_o(nand_cmd_o),
    .rd_req_o(rd_req_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i)
  );

  int n_chk = 0, n_bad = 0;
  int ready_at = NEVER;
  bit fail_flag = 1'b0;
  bit junk_fail = 1'b0;
  int cmd_cnt = 0, rd_cnt = 0, done_cnt = 0;
  int lat = 0, cyc = 0, vld_cyc = 0;
  bit gap_pend = 1'b0, prev_cmd = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_reads(input int tmo, input int rdy);
    int lim = tmo * (1000 / POLL_US) + 1;
    return (rdy <= lim) ? rdy : lim;
  endfunction

  function automatic int exp_res(input int tmo, input int rdy, input bit f);
    int lim = tmo * (1000 / POLL_US) + 1;
    if (rdy > lim) return 1;
    return f ? 2 : 0;
  endfunction

  // Read-path responder and protocol monitor
  always @(negedge clk) begin
    cyc++;
    if (prev_cmd)
      check(nand_ce_o && !nand_cle_o && !nand_we_o, "R3", {nand_ce_o, nand_cle_o, nand_we_o}, 3'b100);
    prev_cmd = nand_we_o;
    if (nand_we_o) begin
      cmd_cnt++;
      check(nand_ce_o && nand_cle_o && nand_cmd_o == 8'h70, "R2", nand_cmd_o, 8'h70);
    end
    if (done_o) begin
      done_cnt++;
      gap_pend = 1'b0;
    end
    rd_vld_i = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        logic [7:0] b;
        rd_cnt++;
        b = 8'($urandom);
        if (rd_cnt >= ready_at) begin
          b[6] = 1'b1;
          b[0] = fail_flag;
        end else begin
          b[6] = 1'b0;
          if (junk_fail) b[0] = 1'b1;
          gap_pend = 1'b1;
          vld_cyc  = cyc;
        end
        rd_data_i = b;
        rd_vld_i  = 1'b1;
      end
    end
    if (rd_req_o) begin
      if (gap_pend) begin
        check(cyc - vld_cyc == IVL + 1, "R4", cyc - vld_cyc, IVL + 1);
        gap_pend = 1'b0;
      end
      lat = 1 + int'($urandom % 3);
    end
  end

  task automatic run_op(input int tmo, input int rdy, input bit f, input bit jf, input bit restart);
    int w;
    int er, ex;
    int got_res;
    @(negedge clk);
    #1;
    ready_at  = rdy;
    fail_flag = f;
    junk_fail = jf;
    cmd_cnt = 0; rd_cnt = 0; done_cnt = 0;
    tmo_ms_i = TMO_W'(tmo);
    start_i  = 1'b1;
    @(negedge clk);
    #1 start_i = 1'b0;
    w = 0;
    got_res = 0;
    while (w < 20000) begin
      @(negedge clk);
      #1;
      w++;
      if (restart && w == 20) start_i = 1'b1;
      if (restart && w == 21) start_i = 1'b0;
      if (done_o) begin
        got_res = int'(result_o);
        break;
      end
    end
    check(w < 20000, "R9", w, 0);
    er = exp_reads(tmo, rdy);
    ex = exp_res(tmo, rdy, f);
    check(got_res == ex, (ex == 1) ? "R6" : ((ex == 2) ? "R7" : "R8"), got_res, ex);
    check(rd_cnt == er, (rdy > er) ? "R5" : "R11", rd_cnt, er);
    @(negedge clk);
    #1;
    check(!done_o && !nand_ce_o, "R9", {done_o, nand_ce_o}, 0);
    repeat (30) @(negedge clk);
    #1;
    check(cmd_cnt == 1 && done_cnt == 1, restart ? "R10" : "R2", cmd_cnt * 10 + done_cnt, 11);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!done_o && !nand_ce_o && !nand_cle_o && !nand_we_o && !rd_req_o, "R1", nand_ce_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(!done_o && !nand_ce_o && !nand_cle_o && !nand_we_o && !rd_req_o, "R1", nand_ce_o, 0);

    // Directed corner cases
    run_op(0, NEVER, 1'b0, 1'b1, 1'b0);  // R5 R6: zero limit, one read, fail bit in junk
    run_op(1, NEVER, 1'b0, 1'b0, 1'b0);  // R5
    run_op(2, NEVER, 1'b0, 1'b1, 1'b0);  // R5 R6
    run_op(1, 101, 1'b0, 1'b0, 1'b0);    // R11: ready on last permitted read
    run_op(1, 102, 1'b1, 1'b0, 1'b0);    // R6: one read too late
    run_op(0, 1, 1'b1, 1'b0, 1'b0);      // R7
    run_op(0, 1, 1'b0, 1'b0, 1'b0);      // R8
    run_op(1, 5, 1'b0, 1'b1, 1'b1);      // R10

    // Random operations
    for (int i = 0; i < 14; i++) begin
      int t = int'($urandom % 3);
      int r = (($urandom % 4) == 0) ? NEVER : 1 + int'($urandom % 150);
      run_op(t, r, 1'($urandom), 1'($urandom), 1'b0);
    end
    finish_run();
  end
endmodule